// File: doc/BRIEF.md
# Pipelined Hamming Top-1 Match Engine

This block finds, for one query hash, the single stored row whose hash agrees with the query in the most bit positions. The rows themselves live outside the block. After a one-cycle query strobe, the engine walks the store through a request/response read port. Each request names a base row index, and the reply delivers one group of lanes: one row ID, one hash and one valid bit per lane.

Every valid lane is scored by counting agreeing bits in a registered popcount tree. A reduction tree then picks the best lane of the beat, and a running-best register keeps the best row seen so far. Once the last group has passed through the pipeline, the winning row index and its score are offered on a valid/ready result port.

A host starts a search, serves read requests from its row store, and collects one result per search. Queries that arrive while a search is running or a result is waiting are dropped.

Top module: `hm_top1_engine`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock edge) is applied and on the first cycle after it, both `req_valid_o` and `res_valid_o` are low.
- R2: A `query_valid_i` pulse seen while idle captures `query_hash_i`. On the next cycle `req_valid_o` is high with `req_base_o` equal to 0.
- R3: At most one read is outstanding. `req_valid_o` and `req_base_o` hold steady until a cycle with `rsp_valid_i` high. The next request then carries base + LANES. After the reply to base ROWS-LANES, no further request is made.
- R4: In a reply, lane i occupies bits [i*ROW_W +: ROW_W] of `rsp_rows_i`, bits [i*HASH_W +: HASH_W] of `rsp_hashes_i` and bit i of `rsp_lane_ok_i`. The reported row is the row ID carried in the reply, not the lane position.
- R5: A row's score is the count of bit positions where its hash equals the query. An identical hash scores HASH_W, and a fully inverted hash scores 0.
- R6: Lanes whose `rsp_lane_ok_i` bit is 0 take no part in the selection.
- R7: The highest score wins. Among equal scores the smaller row ID wins, whether the tied rows share a beat or not.
- R8: `res_valid_o` rises exactly 5 cycles after the clock edge that accepts the last reply (well inside 20). It holds, with row and score stable, until a cycle with `res_ready_i` high, and falls on the following cycle.
- R9: A `query_valid_i` pulse during a sweep, the drain, or while a result waits is ignored. It neither changes the result nor starts a new sweep.
- R10: If no lane is valid during the whole sweep, the result reports row 0 with score 0.
- R11: `rsp_valid_i` asserted while no request is outstanding is ignored and cannot alter a pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| query_valid_i | input | 1 | One-cycle strobe that starts a search |
| query_hash_i | input | HASH_W | Query hash, taken with the strobe |
| req_valid_o | output | 1 | Read request outstanding |
| req_base_o | output | ROW_W | First row index of the requested group |
| rsp_valid_i | input | 1 | Read reply present this cycle |
| rsp_rows_i | input | LANES*ROW_W | Packed row IDs, one per lane |
| rsp_hashes_i | input | LANES*HASH_W | Packed row hashes, one per lane |
| rsp_lane_ok_i | input | LANES | Per-lane valid mask |
| res_valid_o | output | 1 | Result offered |
| res_ready_i | input | 1 | Result taken when high with res_valid_o |
| res_row_o | output | ROW_W | Winning row ID |
| res_score_o | output | SCORE_W | Winning score (agreeing bit count) |

## Verification
A broken address counter or sequencer shows at once on `req_base_o` or `req_valid_o`, at the very next request. Faults in a lane score, the reduction tree or the running best leave no trace until the result. They appear as a wrong row or score exactly five cycles after the last reply. A drain counter that is off by one moves the rising edge of `res_valid_o`. Broken handshake or input gating shows as a result that changes or drops while `res_ready_i` is low, or as a request that appears after a dropped query.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } hm_state_e;

    // Register stages inside one lane scorer: agree vector, half counts, sum.
    localparam int LANE_STAGES = 3;

    // True when candidate a strictly outranks candidate b:
    // higher score, or equal score and smaller row ID.
    function automatic logic outranks(input logic [31:0] score_a, input logic [31:0] row_a,
                                      input logic [31:0] score_b, input logic [31:0] row_b);
        return (score_a > score_b) || ((score_a == score_b) && (row_a < row_b));
    endfunction

endpackage

// File: rtl/hm_sweep.sv
module hm_sweep #(
    parameter int LANES      = 8,
    parameter int ROWS       = 4096,
    parameter int HASH_W     = 32,
    parameter int DRAIN_WAIT = 3,
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              query_valid_i,
    input  logic [HASH_W-1:0] query_hash_i,
    input  logic              rsp_valid_i,
    input  logic              res_ready_i,
    output logic              req_valid_o,
    output logic [ROW_W-1:0]  req_base_o,
    output logic [HASH_W-1:0] query_o,
    output logic              accept_o,
    output logic              clear_o,
    output logic              done_o
);
    import hm_pkg::*;

    localparam int CNT_W = $clog2(DRAIN_WAIT + 1);
    localparam logic [ROW_W-1:0] STEP      = ROW_W'(LANES);
    localparam logic [ROW_W-1:0] LAST_BASE = ROW_W'(ROWS - LANES);

    hm_state_e         state_q;
    logic [ROW_W-1:0]  base_q;
    logic [HASH_W-1:0] query_q;
    logic [CNT_W-1:0]  drain_q;

    assign req_valid_o = (state_q == ST_SCAN);
    assign req_base_o  = base_q;
    assign query_o     = query_q;
    assign accept_o    = (state_q == ST_SCAN) && rsp_valid_i;
    assign clear_o     = (state_q == ST_IDLE) && query_valid_i;
    assign done_o      = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            query_q <= '0;
            drain_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (query_valid_i) begin
                        query_q <= query_hash_i;
                        base_q  <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (rsp_valid_i) begin
                        if (base_q == LAST_BASE) begin
                            drain_q <= CNT_W'(DRAIN_WAIT);
                            state_q <= ST_DRAIN;
                        end else begin
                            base_q <= base_q + STEP;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (drain_q == '0) state_q <= ST_DONE;
                    else               drain_q <= drain_q - 1'b1;
                end
                ST_DONE: begin
                    if (res_ready_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hm_lane_score.sv
module hm_lane_score #(
    parameter int HASH_W   = 32,
    parameter int ROW_W    = 12,
    localparam int SCORE_W = $clog2(HASH_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_v,
    input  logic               ok_i,
    input  logic [HASH_W-1:0]  query_i,
    input  logic [HASH_W-1:0]  hash_i,
    input  logic [ROW_W-1:0]   row_i,
    output logic               out_v,
    output logic [SCORE_W-1:0] score_o,
    output logic [ROW_W-1:0]   row_o
);
    localparam int LO_W = HASH_W / 2;
    localparam int HI_W = HASH_W - LO_W;

    // Stage 1: agreement vector
    logic              v1_q;
    logic [HASH_W-1:0] agree_q;
    logic [ROW_W-1:0]  row1_q;
    // Stage 2: half counts
    logic               v2_q;
    logic [SCORE_W-1:0] lo_q, hi_q;
    logic [ROW_W-1:0]   row2_q;
    // Stage 3: lane score
    logic               v3_q;
    logic [SCORE_W-1:0] sum_q;
    logic [ROW_W-1:0]   row3_q;

    logic [SCORE_W-1:0] lo_n, hi_n;

    always_comb begin
        lo_n = '0;
        for (int i = 0; i < LO_W; i++) lo_n = lo_n + SCORE_W'(agree_q[i]);
        hi_n = '0;
        for (int i = 0; i < HI_W; i++) hi_n = hi_n + SCORE_W'(agree_q[LO_W + i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            v3_q <= 1'b0;
        end else begin
            v1_q <= in_v && ok_i;
            v2_q <= v1_q;
            v3_q <= v2_q;
        end
    end

    always_ff @(posedge clk) begin
        agree_q <= ~(hash_i ^ query_i);
        row1_q  <= row_i;
        lo_q    <= lo_n;
        hi_q    <= hi_n;
        row2_q  <= row1_q;
        sum_q   <= lo_q + hi_q;
        row3_q  <= row2_q;
    end

    assign out_v   = v3_q;
    assign score_o = sum_q;
    assign row_o   = row3_q;
endmodule

// File: rtl/hm_reduce.sv
module hm_reduce #(
    parameter int LANES   = 8,
    parameter int ROW_W   = 12,
    parameter int SCORE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_v_i,
    input  logic [LANES*SCORE_W-1:0] lane_score_i,
    input  logic [LANES*ROW_W-1:0]   lane_row_i,
    output logic                     beat_v_o,
    output logic [SCORE_W-1:0]       beat_score_o,
    output logic [ROW_W-1:0]         beat_row_o
);
    import hm_pkg::*;

    // Heap-ordered tree: node n has children 2n+1 and 2n+2, leaves hold the lanes.
    localparam int NODES = 2 * LANES - 1;
    localparam int FIRST_LEAF = LANES - 1;

    logic [NODES-1:0]   nv;
    logic [SCORE_W-1:0] ns [NODES];
    logic [ROW_W-1:0]   nr [NODES];

    for (genvar n = 0; n < NODES; n++) begin : g_node
        if (n >= FIRST_LEAF) begin : g_leaf
            assign nv[n] = lane_v_i[n - FIRST_LEAF];
            assign ns[n] = lane_score_i[(n - FIRST_LEAF)*SCORE_W +: SCORE_W];
            assign nr[n] = lane_row_i[(n - FIRST_LEAF)*ROW_W +: ROW_W];
        end else begin : g_pick
            logic take_right;
            assign take_right = nv[2*n+2] &&
                (!nv[2*n+1] || outranks(32'(ns[2*n+2]), 32'(nr[2*n+2]),
                                        32'(ns[2*n+1]), 32'(nr[2*n+1])));
            assign nv[n] = nv[2*n+1] || nv[2*n+2];
            assign ns[n] = take_right ? ns[2*n+2] : ns[2*n+1];
            assign nr[n] = take_right ? nr[2*n+2] : nr[2*n+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) beat_v_o <= 1'b0;
        else        beat_v_o <= nv[0];
    end

    always_ff @(posedge clk) begin
        beat_score_o <= ns[0];
        beat_row_o   <= nr[0];
    end
endmodule

// File: rtl/hm_best.sv
module hm_best #(
    parameter int ROW_W   = 12,
    parameter int SCORE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               beat_v_i,
    input  logic [SCORE_W-1:0] beat_score_i,
    input  logic [ROW_W-1:0]   beat_row_i,
    output logic [ROW_W-1:0]   best_row_o,
    output logic [SCORE_W-1:0] best_score_o
);
    import hm_pkg::*;

    logic               have_q;
    logic [ROW_W-1:0]   row_q;
    logic [SCORE_W-1:0] score_q;
    logic               replace;

    assign replace = beat_v_i &&
        (!have_q || outranks(32'(beat_score_i), 32'(beat_row_i), 32'(score_q), 32'(row_q)));

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            have_q  <= 1'b0;
            row_q   <= '0;
            score_q <= '0;
        end else if (replace) begin
            have_q  <= 1'b1;
            row_q   <= beat_row_i;
            score_q <= beat_score_i;
        end
    end

    assign best_row_o   = row_q;
    assign best_score_o = score_q;
endmodule

// File: rtl/hm_top1_engine.sv
module hm_top1_engine #(
    parameter int LANES    = 8,
    parameter int ROWS     = 4096,
    parameter int HASH_W   = 32,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int SCORE_W = $clog2(HASH_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    query_valid_i,
    input  logic [HASH_W-1:0]       query_hash_i,
    output logic                    req_valid_o,
    output logic [ROW_W-1:0]        req_base_o,
    input  logic                    rsp_valid_i,
    input  logic [LANES*ROW_W-1:0]  rsp_rows_i,
    input  logic [LANES*HASH_W-1:0] rsp_hashes_i,
    input  logic [LANES-1:0]        rsp_lane_ok_i,
    output logic                    res_valid_o,
    input  logic                    res_ready_i,
    output logic [ROW_W-1:0]        res_row_o,
    output logic [SCORE_W-1:0]      res_score_o
);
    import hm_pkg::*;

    // Lane stages + beat register + running best, counted from the accepting edge.
    localparam int PIPE_DEPTH = LANE_STAGES + 2;
    localparam int DRAIN_WAIT = PIPE_DEPTH - 2;

    logic [HASH_W-1:0]        query;
    logic                     accept, clear;
    logic [LANES-1:0]         lane_v;
    logic [LANES*SCORE_W-1:0] lane_score;
    logic [LANES*ROW_W-1:0]   lane_row;
    logic                     beat_v;
    logic [SCORE_W-1:0]       beat_score;
    logic [ROW_W-1:0]         beat_row;

    hm_sweep #(
        .LANES(LANES), .ROWS(ROWS), .HASH_W(HASH_W), .DRAIN_WAIT(DRAIN_WAIT)
    ) i_sweep (
        .clk(clk), .rst_n(rst_n),
        .query_valid_i(query_valid_i), .query_hash_i(query_hash_i),
        .rsp_valid_i(rsp_valid_i), .res_ready_i(res_ready_i),
        .req_valid_o(req_valid_o), .req_base_o(req_base_o),
        .query_o(query), .accept_o(accept), .clear_o(clear), .done_o(res_valid_o)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        hm_lane_score #(.HASH_W(HASH_W), .ROW_W(ROW_W)) i_score (
            .clk(clk), .rst_n(rst_n),
            .in_v(accept), .ok_i(rsp_lane_ok_i[l]),
            .query_i(query),
            .hash_i(rsp_hashes_i[l*HASH_W +: HASH_W]),
            .row_i(rsp_rows_i[l*ROW_W +: ROW_W]),
            .out_v(lane_v[l]),
            .score_o(lane_score[l*SCORE_W +: SCORE_W]),
            .row_o(lane_row[l*ROW_W +: ROW_W])
        );
    end

    hm_reduce #(.LANES(LANES), .ROW_W(ROW_W), .SCORE_W(SCORE_W)) i_reduce (
        .clk(clk), .rst_n(rst_n),
        .lane_v_i(lane_v), .lane_score_i(lane_score), .lane_row_i(lane_row),
        .beat_v_o(beat_v), .beat_score_o(beat_score), .beat_row_o(beat_row)
    );

    hm_best #(.ROW_W(ROW_W), .SCORE_W(SCORE_W)) i_best (
        .clk(clk), .rst_n(rst_n), .clear_i(clear),
        .beat_v_i(beat_v), .beat_score_i(beat_score), .beat_row_i(beat_row),
        .best_row_o(res_row_o), .best_score_o(res_score_o)
    );
endmodule

// File: rtl/hm_top1_engine_chk.sv
module hm_top1_engine_chk #(
    parameter int LANES    = 8,
    parameter int ROWS     = 4096,
    parameter int HASH_W   = 32,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int SCORE_W = $clog2(HASH_W + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               query_valid_i,
    input logic               req_valid_o,
    input logic [ROW_W-1:0]   req_base_o,
    input logic               rsp_valid_i,
    input logic               res_valid_o,
    input logic               res_ready_i,
    input logic [ROW_W-1:0]   res_row_o,
    input logic [SCORE_W-1:0] res_score_o
);
    localparam logic [ROW_W-1:0] LAST_BASE = ROW_W'(ROWS - LANES);
    localparam logic [ROW_W-1:0] STEP      = ROW_W'(LANES);

    logic       pend_q;
    logic [4:0] wait_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wait_q <= '0;
        end else if (req_valid_o && rsp_valid_i && req_base_o == LAST_BASE) begin
            pend_q <= 1'b1;
            wait_q <= '0;
        end else if (res_valid_o) begin
            pend_q <= 1'b0;
        end else if (pend_q && wait_q != 5'd31) begin
            wait_q <= wait_q + 5'd1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !req_valid_o && !res_valid_o);

    p_first_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> req_base_o == '0);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !rsp_valid_i |=> req_valid_o && $stable(req_base_o));

    p_base_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && rsp_valid_i && req_base_o != LAST_BASE
        |=> req_valid_o && req_base_o == $past(req_base_o) + STEP);

    p_sweep_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && rsp_valid_i && req_base_o == LAST_BASE |=> !req_valid_o);

    p_score_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> 32'(res_score_o) <= HASH_W);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_o && res_valid_o));

    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && !res_ready_i
        |=> res_valid_o && $stable(res_row_o) && $stable(res_score_o));

    p_res_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && res_ready_i |=> !res_valid_o);

    p_res_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_q && wait_q >= 5'd20));

    p_query_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && !res_ready_i && query_valid_i |=> !req_valid_o);
endmodule

bind hm_top1_engine hm_top1_engine_chk #(
    .LANES(LANES), .ROWS(ROWS), .HASH_W(HASH_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .query_valid_i(query_valid_i),
    .req_valid_o(req_valid_o), .req_base_o(req_base_o), .rsp_valid_i(rsp_valid_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_row_o(res_row_o), .res_score_o(res_score_o)
);

// File: tb/test_hm_top1_engine.sv
`timescale 1ns/1ps
module test_hm_top1_engine;
    localparam int LANES   = 8;
    localparam int ROWS    = 64;
    localparam int HASH_W  = 16;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int SCORE_W = $clog2(HASH_W + 1);
    localparam int NB      = ROWS / LANES;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    query_valid_i;
    logic [HASH_W-1:0]       query_hash_i;
    logic                    req_valid_o;
    logic [ROW_W-1:0]        req_base_o;
    logic                    rsp_valid_i;
    logic [LANES*ROW_W-1:0]  rsp_rows_i;
    logic [LANES*HASH_W-1:0] rsp_hashes_i;
    logic [LANES-1:0]        rsp_lane_ok_i;
    logic                    res_valid_o;
    logic                    res_ready_i;
    logic [ROW_W-1:0]        res_row_o;
    logic [SCORE_W-1:0]      res_score_o;

    hm_top1_engine #(.LANES(LANES), .ROWS(ROWS), .HASH_W(HASH_W)) i_hm_top1_engine (
        .clk(clk), .rst_n(rst_n),
        .query_valid_i(query_valid_i), .query_hash_i(query_hash_i),
        .req_valid_o(req_valid_o), .req_base_o(req_base_o),
        .rsp_valid_i(rsp_valid_i), .rsp_rows_i(rsp_rows_i),
        .rsp_hashes_i(rsp_hashes_i), .rsp_lane_ok_i(rsp_lane_ok_i),
        .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
        .res_row_o(res_row_o), .res_score_o(res_score_o)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [HASH_W-1:0] mem [ROWS];
    bit                okm [ROWS];
    bit                rev_ids = 1'b0;
    logic [31:0]       seed = 32'h1234_5678;

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic int id_of(input int b, input int lane);
        return rev_ids ? b*LANES + (LANES-1-lane) : b*LANES + lane;
    endfunction

    // Independent reference: agreeing-bit count, lowest ID on ties, row 0/score 0 if none.
    task automatic model(input logic [HASH_W-1:0] q, output int er, output int es);
        bit have = 1'b0;
        er = 0; es = 0;
        for (int id = 0; id < ROWS; id++) begin
            if (okm[id]) begin
                int s = HASH_W - $countones(mem[id] ^ q);
                if (!have || s > es) begin
                    have = 1'b1; er = id; es = s;
                end
            end
        end
    endtask

    task automatic fill(input int mode, input logic [HASH_W-1:0] q);
        for (int id = 0; id < ROWS; id++) begin
            okm[id] = 1'b1;
            case (mode)
                0: mem[id] = '0;
                1: mem[id] = ~q;
                default: begin
                    mem[id] = HASH_W'(rnd());
                    if (mem[id] == q) mem[id] = q ^ HASH_W'(1);
                end
            endcase
        end
    endtask

    task automatic run_search(input logic [HASH_W-1:0] q, input int gap, input int stray_beat,
                              input int hold, input string name);
        int er, es, k;
        model(q, er, es);
        @(negedge clk);
        res_ready_i   = (hold == 0);
        query_valid_i = 1'b1;
        query_hash_i  = q;
        @(negedge clk);
        query_valid_i = 1'b0;
        query_hash_i  = ~q;
        check("R2 request raised after query", req_valid_o, 1);
        check("R2 first base is zero", req_base_o, 0);
        for (int b = 0; b < NB; b++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R3 request held while waiting", req_valid_o, 1);
            end
            check("R3 base of group", req_base_o, b*LANES);
            for (int lane = 0; lane < LANES; lane++) begin
                int id = id_of(b, lane);
                rsp_rows_i[lane*ROW_W +: ROW_W]     = ROW_W'(id);
                rsp_hashes_i[lane*HASH_W +: HASH_W] = mem[id];
                rsp_lane_ok_i[lane]                 = okm[id];
            end
            rsp_valid_i = 1'b1;
            if (b == stray_beat) begin
                query_valid_i = 1'b1;      // R9: must be ignored mid-sweep
                query_hash_i  = ~q;
            end
            @(negedge clk);
            rsp_valid_i   = 1'b0;
            query_valid_i = 1'b0;
        end
        check("R3 no request after last group", req_valid_o, 0);
        k = 1;
        while (!res_valid_o && k < 30) begin
            @(negedge clk);
            k++;
        end
        check({name, " R8 result latency"}, k, 5);
        check({name, " row"}, res_row_o, er);
        check({name, " score"}, res_score_o, es);
        if (hold > 0) begin
            for (int h = 0; h < hold; h++) begin
                if (h == 1) begin
                    query_valid_i = 1'b1;   // R9
                    query_hash_i  = q;
                    rsp_valid_i   = 1'b1;   // R11: stray exact match on row 0
                    rsp_rows_i    = '0;
                    rsp_hashes_i  = {LANES{q}};
                    rsp_lane_ok_i = '1;
                end
                @(negedge clk);
                query_valid_i = 1'b0;
                rsp_valid_i   = 1'b0;
                check("R8 result held without ready", res_valid_o, 1);
                check("R11 row unchanged by stray reply", res_row_o, er);
                check("R11 score unchanged by stray reply", res_score_o, es);
            end
            res_ready_i = 1'b1;
            @(negedge clk);
            check("R8 result released after ready", res_valid_o, 0);
            check("R9 dropped query started no sweep", req_valid_o, 0);
            repeat (8) @(negedge clk);
            check("R11 no result from stray reply", res_valid_o, 0);
            check("R9 still idle", req_valid_o, 0);
        end else begin
            @(negedge clk);
            check("R8 result released after ready", res_valid_o, 0);
        end
    endtask

    initial begin
        int er, es;
        logic [HASH_W-1:0] q;
        rst_n = 1'b0;
        query_valid_i = 1'b0; query_hash_i = '0;
        rsp_valid_i = 1'b0; rsp_rows_i = '0; rsp_hashes_i = '0; rsp_lane_ok_i = '0;
        res_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 no request in reset", req_valid_o, 0);
        check("R1 no result in reset", res_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", req_valid_o, 0);

        // Exact match at row 9
        q = '1;
        fill(0, q);
        mem[9] = q;
        run_search(q, 0, -1, 0, "R5 exact match");

        // Every row inverted: all score 0, row 0 wins the tie
        q = 16'hA5C3;
        fill(1, q);
        run_search(q, 1, -1, 0, "R5 R7 all inverted");

        // Random store, reversed lane IDs, slow replies, query mid-sweep
        rev_ids = 1'b1;
        q = HASH_W'(rnd());
        fill(2, q);
        run_search(q, 2, 3, 0, "R4 R9 random reversed");

        // Ties across and inside beats
        q = 16'h3C5A;
        fill(1, q);
        mem[45] = q ^ 16'h0100;
        mem[20] = q ^ 16'h0001;
        mem[18] = q ^ 16'h8000;
        run_search(q, 0, -1, 0, "R7 tie lowest row");
        rev_ids = 1'b0;

        // Masked lanes: the best row and a random subset are excluded
        q = HASH_W'(rnd());
        fill(2, q);
        model(q, er, es);
        okm[er] = 1'b0;
        for (int id = 0; id < ROWS; id++) if (rnd() % 4 == 0) okm[id] = 1'b0;
        run_search(q, 1, -1, 0, "R6 masked lanes");

        // No valid lane at all
        q = HASH_W'(rnd());
        fill(2, q);
        for (int id = 0; id < ROWS; id++) okm[id] = 1'b0;
        run_search(q, 0, -1, 0, "R10 empty sweep");

        // Result held without ready; stray query and reply ignored
        q = HASH_W'(rnd());
        fill(2, q);
        run_search(q, 0, -1, 4, "R8 R9 R11 held result");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule